// File: doc/BRIEF.md
# Segment-and-Page Address Translation Walker

The block turns a logical address into a physical one. A logical address has three fields: a segment number, a page number and an offset inside the page. The segment number first goes through a range check against the length of the current process's segment table. It then selects a segment descriptor in memory. The descriptor names the base and the length of that segment's own page table. The page number goes through a range check against that length. It then selects a page entry that holds the frame number. The physical address is the frame number placed above the unchanged offset.

A small fully associative translation cache, keyed on segment and page number, sits in front of the walk. On a hit both table reads are skipped. On a miss two reads are issued, one at a time, through a simple memory read port. A successful walk refills the cache in round-robin order. The base and length of the segment table are inputs held by the process context. They are captured when a request is accepted. A result is reported as a one-cycle done pulse with a registered physical address and a two-bit fault code.

Top module: `segpage_xlate`

## Requirements
- R1: On success the physical address is {frame, offset}: the frame sits in the upper FRAME_W bits and the request offset is passed unchanged in the lower OFF_W bits. The fault code is 00.
- R2: A segment number greater than or equal to the captured segment-table length ends the request with fault 01 and issues no memory read.
- R3: The segment descriptor is read from address segment-table base + segment number. Bits [ADDR_W-1:0] of the descriptor hold the page-table base. Bits [ADDR_W+PAGE_W:ADDR_W] hold the page-table length (by default bits 15:0 and 20:16).
- R4: A page number greater than or equal to the page-table length from the descriptor ends the request with fault 10 after exactly one memory read.
- R5: The page entry is read from page-table base + page number. Bit DATA_W-1 (bit 31) is the valid flag and bits [FRAME_W-1:0] hold the frame. A cleared valid flag ends the request with fault 11 after two reads.
- R6: A cache miss that translates successfully costs exactly two memory reads and installs the segment/page-to-frame mapping in the cache.
- R7: A cache hit on an in-range segment completes with no memory read and gives the same physical address as the walk.
- R8: The segment range check also applies when the mapping is cached. When a cached segment is out of range, fault 01 takes priority over the hit.
- R9: At most one memory read is outstanding. mem_req is a one-cycle pulse, and the next one is issued only after mem_rvalid has returned the previous data.
- R10: A request is taken only while req_ready is high. done is a single-cycle pulse for each accepted request.
- R11: The cache holds CACHE_N mappings and replaces them in round-robin order. After CACHE_N further distinct fills, a mapping is evicted and needs a two-read walk again.
- R12: After reset req_ready is high, done and mem_req are low and the cache is empty, so the first translation walks the tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_seg | input | SEG_W | Segment number |
| req_page | input | PAGE_W | Page number |
| req_off | input | OFF_W | Offset within the page |
| st_base | input | ADDR_W | Segment-table base address |
| st_len | input | SEG_W+1 | Number of segment-table entries |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| done | output | 1 | Result valid pulse |
| paddr | output | FRAME_W+OFF_W | Physical address |
| fault | output | 2 | 00 none, 01 segment range, 10 page range, 11 invalid page entry |

## Verification
The segment range check and the cache lookup are settled in the same lookup cycle, so a cached mapping can meet an out-of-range segment. The bench provokes this by translating an address so that it is cached, and then shrinking the segment-table length below that segment. The outcome must be fault 01 with zero memory reads, not a hit. Random traffic with a varying table length repeats the collision many times. A bench cache model predicts hits and evictions, and each result is judged on its fault code, physical address and read count.

// File: rtl/segpage_pkg.sv
package segpage_pkg;

  typedef enum logic [1:0] {
    WS_IDLE     = 2'd0,
    WS_LOOKUP   = 2'd1,
    WS_READ_SEG = 2'd2,
    WS_READ_PTE = 2'd3
  } walk_state_t;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_SEG     = 2'b01,
    FLT_PAGE    = 2'b10,
    FLT_INVALID = 2'b11
  } fault_t;

endpackage

// File: rtl/segpage_cache.sv
module segpage_cache #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 7,
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               fill_en,
  input  logic [FRAME_W-1:0] fill_frame
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = valid_q[i] && (tag_q[i] == lk_tag);
  end

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_frame = lk_frame | frame_q[i];
    end
  end
  assign lk_hit = |match;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (fill_en) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_en && (ptr_q == PTR_W'(i))) begin
        tag_q[i]   <= lk_tag;
        frame_q[i] <= fill_frame;
      end
    end
  end

  // R11: a tag never sits in two slots
  a_r11_unique_tags: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  // R7: refill only happens after a miss
  a_r7_fill_on_miss: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> !lk_hit);

  // R11: the slot under the pointer receives the fill
  a_r11_fill_lands: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (valid_q[$past(ptr_q)] && tag_q[$past(ptr_q)] == $past(lk_tag)));

endmodule

// File: rtl/segpage_walk.sv
module segpage_walk
  import segpage_pkg::*;
#(
  parameter int SEG_W   = 3,
  parameter int PAGE_W  = 4,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [SEG_W-1:0]          req_seg,
  input  logic [PAGE_W-1:0]         req_page,
  input  logic [OFF_W-1:0]          req_off,
  input  logic [ADDR_W-1:0]         st_base,
  input  logic [SEG_W:0]            st_len,
  output logic [SEG_W+PAGE_W-1:0]   lk_tag,
  input  logic                      lk_hit,
  input  logic [FRAME_W-1:0]        lk_frame,
  output logic                      fill_en,
  output logic [FRAME_W-1:0]        fill_frame,
  output logic                      mem_req,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic                      mem_rvalid,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic                      done,
  output logic [FRAME_W+OFF_W-1:0]  paddr,
  output logic [1:0]                fault
);
  localparam int PLEN_W  = PAGE_W + 1;
  localparam int VLD_BIT = DATA_W - 1;

  walk_state_t       state_q;
  logic [SEG_W-1:0]  seg_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic [ADDR_W-1:0] stbase_q;
  logic [SEG_W:0]    stlen_q;

  logic [ADDR_W-1:0] ste_base;
  logic [PLEN_W-1:0] ste_len;
  logic              seg_oob;
  logic              page_oob;
  logic              pte_ok;

  assign ste_base   = mem_rdata[ADDR_W-1:0];
  assign ste_len    = mem_rdata[ADDR_W +: PLEN_W];
  assign pte_ok     = mem_rdata[VLD_BIT];
  assign seg_oob    = {1'b0, seg_q} >= stlen_q;
  assign page_oob   = {1'b0, page_q} >= ste_len;
  assign lk_tag     = {seg_q, page_q};
  assign fill_frame = mem_rdata[FRAME_W-1:0];
  assign fill_en    = (state_q == WS_READ_PTE) && mem_rvalid && pte_ok;
  assign req_ready  = (state_q == WS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= WS_IDLE;
      seg_q    <= '0;
      page_q   <= '0;
      off_q    <= '0;
      stbase_q <= '0;
      stlen_q  <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      paddr    <= '0;
      fault    <= FLT_NONE;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      unique case (state_q)
        WS_IDLE: begin
          if (req_valid) begin
            seg_q    <= req_seg;
            page_q   <= req_page;
            off_q    <= req_off;
            stbase_q <= st_base;
            stlen_q  <= st_len;
            state_q  <= WS_LOOKUP;
          end
        end
        WS_LOOKUP: begin
          if (seg_oob) begin
            done    <= 1'b1;
            fault   <= FLT_SEG;
            state_q <= WS_IDLE;
          end else if (lk_hit) begin
            done    <= 1'b1;
            fault   <= FLT_NONE;
            paddr   <= {lk_frame, off_q};
            state_q <= WS_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= stbase_q + ADDR_W'(seg_q);
            state_q  <= WS_READ_SEG;
          end
        end
        WS_READ_SEG: begin
          if (mem_rvalid) begin
            if (page_oob) begin
              done    <= 1'b1;
              fault   <= FLT_PAGE;
              state_q <= WS_IDLE;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= ste_base + ADDR_W'(page_q);
              state_q  <= WS_READ_PTE;
            end
          end
        end
        WS_READ_PTE: begin
          if (mem_rvalid) begin
            done    <= 1'b1;
            state_q <= WS_IDLE;
            if (pte_ok) begin
              fault <= FLT_NONE;
              paddr <= {fill_frame, off_q};
            end else begin
              fault <= FLT_INVALID;
            end
          end
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  // R9: read strobe lasts one cycle
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R9: data only returns while a read is pending
  a_r9_rvalid_pending: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |-> (state_q == WS_READ_SEG || state_q == WS_READ_PTE));

  // R10: one done pulse per request
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2, R8: out-of-range segment wins over a hit, with no read
  a_r8_seg_first: assert property (@(posedge clk) disable iff (rst)
    (state_q == WS_LOOKUP && seg_oob) |=> (done && fault == FLT_SEG && !mem_req));

  // R1: offset passes through unchanged
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (done && fault == FLT_NONE) |-> (paddr[OFF_W-1:0] == off_q));

endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate #(
  parameter int SEG_W   = 3,
  parameter int PAGE_W  = 4,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int CACHE_N = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [SEG_W-1:0]         req_seg,
  input  logic [PAGE_W-1:0]        req_page,
  input  logic [OFF_W-1:0]         req_off,
  input  logic [ADDR_W-1:0]        st_base,
  input  logic [SEG_W:0]           st_len,
  output logic                     mem_req,
  output logic [ADDR_W-1:0]        mem_addr,
  input  logic                     mem_rvalid,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic                     done,
  output logic [FRAME_W+OFF_W-1:0] paddr,
  output logic [1:0]               fault
);
  localparam int TAG_W = SEG_W + PAGE_W;

  logic [TAG_W-1:0]   lk_tag;
  logic               lk_hit;
  logic [FRAME_W-1:0] lk_frame;
  logic               fill_en;
  logic [FRAME_W-1:0] fill_frame;

  segpage_walk #(
    .SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
    .FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_walk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_page(req_page), .req_off(req_off),
    .st_base(st_base), .st_len(st_len),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_frame(lk_frame),
    .fill_en(fill_en), .fill_frame(fill_frame),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .paddr(paddr), .fault(fault)
  );

  segpage_cache #(
    .ENTRIES(CACHE_N), .TAG_W(TAG_W), .FRAME_W(FRAME_W)
  ) u_cache (
    .clk(clk), .rst(rst),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_frame(lk_frame),
    .fill_en(fill_en), .fill_frame(fill_frame)
  );

endmodule

// File: tb/tb_segpage_xlate.sv
module tb_segpage_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam logic [15:0] ST_BASE = 16'h0100;
  localparam logic [15:0] PT_BASE = 16'h0200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_seg = '0;
  logic [3:0]  req_page = '0;
  logic [7:0]  req_off = '0;
  logic [15:0] st_base = ST_BASE;
  logic [3:0]  st_len = 4'd8;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [15:0] paddr;
  logic [1:0]  fault;

  int n_vec = 0;
  int n_bad = 0;
  int rd_total = 0;
  int overlap = 0;
  logic        pend = 1'b0;
  int          lat = 0;
  logic [15:0] a_q = '0;

  int ctag [NC];
  bit cval [NC];
  int cptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segpage_xlate dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_page(req_page), .req_off(req_off),
    .st_base(st_base), .st_len(st_len),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .paddr(paddr), .fault(fault)
  );

  function automatic int seg_len(input int s);
    return (s * 5 + 3) % 17;
  endfunction

  function automatic int frm(input int s, input int p);
    return ((s * 16 + p) * 7 + 1) & 255;
  endfunction

  function automatic bit pte_valid(input int s, input int p);
    return ((s + p) % 5) != 4;
  endfunction

  function automatic logic [31:0] mem_word(input logic [15:0] a);
    int s, p;
    if (a >= ST_BASE && a < ST_BASE + 16'd8) begin
      s = int'(a - ST_BASE);
      return {11'b0, 5'(seg_len(s)), PT_BASE + 16'(s * 16)};
    end else if (a >= PT_BASE && a < PT_BASE + 16'd128) begin
      s = int'(a - PT_BASE) / 16;
      p = int'(a - PT_BASE) % 16;
      return {pte_valid(s, p), 23'b0, 8'(frm(s, p))};
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) begin
      pend <= 1'b0;
    end else if (mem_req) begin
      if (pend) overlap <= overlap + 1;
      pend     <= 1'b1;
      a_q      <= mem_addr;
      lat      <= 1 + int'($urandom % 3);
      rd_total <= rd_total + 1;
    end else if (pend) begin
      if (lat <= 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_word(a_q);
        pend       <= 1'b0;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic xlate(input int s, input int p, input int stl, input string rq,
                       output int reads_out);
    int ef, eframe, ereads, r0, t;
    bit hit;
    logic [7:0] off;
    ef = 0; eframe = 0; ereads = 0; hit = 0;
    if (s >= stl) begin
      ef = 1;
    end else begin
      for (int i = 0; i < NC; i++)
        if (cval[i] && ctag[i] == s * 16 + p) hit = 1;
      if (hit) begin
        eframe = frm(s, p);
      end else if (p >= seg_len(s)) begin
        ef = 2; ereads = 1;
      end else begin
        ereads = 2;
        if (pte_valid(s, p)) begin
          eframe = frm(s, p);
          ctag[cptr] = s * 16 + p;
          cval[cptr] = 1'b1;
          cptr = (cptr + 1) % NC;
        end else begin
          ef = 3;
        end
      end
    end
    off = 8'($urandom);
    @(negedge clk);
    t = 0;
    while (!req_ready && t < 50) begin @(negedge clk); t++; end
    chk(req_ready, {rq, " R10 ready"}, req_ready, 1);
    req_valid = 1'b1; req_seg = 3'(s); req_page = 4'(p); req_off = off;
    st_len = 4'(stl);
    r0 = rd_total;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 40) begin @(negedge clk); t++; end
    reads_out = rd_total - r0;
    if (!done) begin
      chk(1'b0, {rq, " watchdog no done"}, 0, 1);
    end else begin
      chk(fault == 2'(ef), {rq, " fault"}, fault, ef);
      if (ef == 0) chk(paddr == {8'(eframe), off}, {rq, " R1 paddr"}, paddr, {8'(eframe), off});
      chk(reads_out == ereads, {rq, " reads"}, reads_out, ereads);
      @(negedge clk);
      chk(!done, {rq, " R10 done pulse"}, done, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int rd, s, p, stl;
    void'($urandom(32'd1234));
    for (int i = 0; i < NC; i++) begin cval[i] = 1'b0; ctag[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready, "R12 ready after reset", req_ready, 1);
    chk(!done, "R12 done low after reset", done, 0);
    chk(!mem_req, "R12 mem_req low after reset", mem_req, 0);

    xlate(0, 2, 8, "R12 R6 first walk", rd);
    chk(rd == 2, "R6 two reads on miss", rd, 2);
    xlate(0, 2, 8, "R7 hit", rd);
    chk(rd == 0, "R7 no reads on hit", rd, 0);
    xlate(3, 1, 8, "R4 page range", rd);
    xlate(1, 3, 8, "R5 invalid entry", rd);
    xlate(7, 3, 8, "R3 last segment", rd);
    xlate(7, 0, 7, "R2 segment range", rd);
    xlate(2, 1, 8, "R3 fill", rd);
    xlate(2, 1, 2, "R8 cached but out of range", rd);
    chk(rd == 0, "R8 no read on segment fault", rd, 0);
    xlate(2, 1, 8, "R8 hit again in range", rd);

    xlate(6, 0, 8, "R11 victim fill", rd);
    xlate(6, 1, 8, "R11 fill", rd);
    xlate(6, 2, 8, "R11 fill", rd);
    xlate(6, 4, 8, "R11 fill", rd);
    xlate(6, 5, 8, "R11 fill", rd);
    xlate(6, 0, 8, "R11 evicted", rd);
    chk(rd == 2, "R11 evicted mapping walks again", rd, 2);

    for (int n = 0; n < 300; n++) begin
      s = int'($urandom % 8);
      p = ($urandom % 3 == 0) ? int'($urandom % 16) : int'($urandom % 4);
      stl = ($urandom % 4 == 0) ? 4 + int'($urandom % 4) : 8;
      xlate(s, p, stl, "R1 R2 R4 R5 R7 R8 random", rd);
    end

    chk(overlap == 0, "R9 single outstanding read", overlap, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule